// File: doc/BRIEF.md
# Transfer Byte Counter with Address Tracking

This block keeps the bookkeeping for a byte-serial transfer engine. The host loads a remaining-byte count, one byte lane per register write, and loads a start address. Two address copies then move forward independently. The issue-side copy steps each time a byte is launched, and it may run ahead of the data actually delivered. The completion-side copy steps only when a byte is confirmed delivered. The count also moves down only on confirmed delivery. After a stall or abort, software therefore reads the completion-side address and the count to find exactly where the transfer stands.

Two sticky status flags are kept. The first marks that the count has reached zero. The second marks that a completion arrived with the count already at zero, so the counter rolled over to all ones. Software clears either flag by writing 1 to the status location. Each flag has its own enable bit, and the enabled flags are ORed onto a single interrupt line. A control bit zeroes the count in one cycle. Host writes to the count always win over a completion pulse in the same cycle.

Top module: `xfer_count_track`

## Requirements
- R1: After reset the count, both address copies, the status flags and the enables are all zero, and `irq` is low.
- R2: Count bytes are written and read at offsets 0, 1 and 2. Offset 0 holds bits 7:0, offset 1 holds bits 15:8 and offset 2 holds bits 23:16.
- R3: A `xferDone` pulse with no count write in the same cycle lowers the count by one and raises the completion address (read at offsets 8..11, offset 8 least significant) by one, visible from the next cycle.
- R4: A `xferIssue` pulse raises the issue address (read at offsets 12..15, offset 12 least significant) by one. The count and the completion address are unaffected.
- R5: Writing an issue-address byte at offset 12+k loads that byte into both the issue address and the completion address. This write takes priority over an increment of either copy in the same cycle.
- R6: A completion that takes the count from 1 to 0 sets status bit 0 (done). A completion that arrives with the count at 0 makes the count all ones and sets status bit 1 (wrap).
- R7: Status is read at offset 4. Writing offset 4 clears each status bit whose written bit is 1 and leaves bits written as 0 alone. If a flag is set and cleared in the same cycle, the set wins.
- R8: The enable register at offset 5 uses the same bit positions as status. `irq` is high exactly when some status bit and its enable bit are both 1.
- R9: Writing 1 to bit 0 at offset 3 (control, reads as 0) zeroes the count on the next cycle. A same-cycle completion is dropped: the completion address does not move and no status flag is set.
- R10: A write to a count byte in the same cycle as a completion pulse takes the written value, and that completion is dropped. The completion address does not move and no status flag is set.
- R11: Writes to the completion-address offsets 8..11 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Host register write strobe |
| regAddr | input | 4 | Host register offset for read and write |
| regWdata | input | 8 | Host write data |
| regRdata | output | 8 | Read data for `regAddr` (combinational) |
| xferIssue | input | 1 | One byte launched this cycle |
| xferDone | input | 1 | One byte confirmed delivered this cycle |
| irq | output | 1 | Interrupt request from the enabled status flags |

## Verification
Issue pulses alone are applied to show that launching moves only the issue address. Completion pulses alone are applied to show that delivery moves the count and the completion address together, including a carry across an address byte boundary. Completions at counts of 1 and 0 separate the done event from the wrap event. With only one enable set, each event is shown to reach `irq` only through its own enable bit. Same-cycle collisions are driven: count clear with completion, count byte write with completion, and a flag clear with a flag set. These show which side wins each collision and that a dropped completion leaves the address and the status untouched.

// File: rtl/xfer_count_pkg.sv
package xfer_count_pkg;

  localparam int LANE_W    = 8;
  localparam int MAX_LANES = 4;
  localparam int STAT_W    = 2;

  localparam logic [3:0] OFF_CTRL  = 4'd3;
  localparam logic [3:0] OFF_STAT  = 4'd4;
  localparam logic [3:0] OFF_EN    = 4'd5;
  localparam logic [3:0] OFF_CADDR = 4'd8;
  localparam logic [3:0] OFF_IADDR = 4'd12;

  localparam int STAT_DONE = 0;
  localparam int STAT_WRAP = 1;

  typedef struct packed {
    logic [MAX_LANES-1:0] cntByteWe;
    logic [MAX_LANES-1:0] addrByteWe;
    logic                 cntClr;
    logic                 accept;
    logic                 issue;
    logic [LANE_W-1:0]    wdata;
  } xfer_strobe_t;

endpackage

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_count_pkg::*;
#(
  parameter int CNT_BYTES  = 3,
  parameter int ADDR_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [3:0]        regAddr,
  input  logic [LANE_W-1:0] regWdata,
  input  logic              xferDone,
  input  logic              xferIssue,
  input  logic              doneEv,
  input  logic              wrapEv,
  output xfer_strobe_t      strobe,
  output logic [STAT_W-1:0] statusQ,
  output logic [STAT_W-1:0] enableQ,
  output logic              irq
);

  logic [MAX_LANES-1:0] cntWe;
  logic [MAX_LANES-1:0] addrWe;
  logic                 clrCount;
  logic [STAT_W-1:0]    clrMask;
  logic [STAT_W-1:0]    setMask;
  logic [STAT_W-1:0]    statusD;

  for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
    if (i < CNT_BYTES) begin : g_cnt
      assign cntWe[i] = regWe && (regAddr == 4'(i));
    end else begin : g_nocnt
      assign cntWe[i] = 1'b0;
    end
    if (i < ADDR_BYTES) begin : g_addr
      assign addrWe[i] = regWe && (regAddr == 4'(OFF_IADDR + 4'(i)));
    end else begin : g_noaddr
      assign addrWe[i] = 1'b0;
    end
  end

  assign clrCount = regWe && (regAddr == OFF_CTRL) && regWdata[0];

  always_comb begin
    strobe            = '0;
    strobe.cntByteWe  = cntWe;
    strobe.addrByteWe = addrWe;
    strobe.cntClr     = clrCount;
    strobe.accept     = xferDone && !(|cntWe) && !clrCount;
    strobe.issue      = xferIssue;
    strobe.wdata      = regWdata;
  end

  assign clrMask = (regWe && regAddr == OFF_STAT) ? regWdata[STAT_W-1:0] : '0;

  always_comb begin
    setMask            = '0;
    setMask[STAT_DONE] = doneEv;
    setMask[STAT_WRAP] = wrapEv;
    statusD            = (statusQ & ~clrMask) | setMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
    end else begin
      statusQ <= statusD;
      if (regWe && regAddr == OFF_EN) enableQ <= regWdata[STAT_W-1:0];
    end
  end

  assign irq = |(statusQ & enableQ);

  // R6: the done event shows up as a sticky flag
  p_done_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    doneEv |=> statusQ[STAT_DONE]);

  // R6: the wrap event shows up as a sticky flag
  p_wrap_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrapEv |=> statusQ[STAT_WRAP]);

  // R7: a 1 written to the done bit clears it unless a new set arrives
  p_w1c_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == OFF_STAT && regWdata[STAT_DONE] && !doneEv)
      |=> !statusQ[STAT_DONE]);

  // R7: flags without a set or clear hold their value
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!(regWe && regAddr == OFF_STAT) && !doneEv && !wrapEv) |=> $stable(statusQ));

  // R10: a completion colliding with a count write is never accepted
  p_drop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && (|cntWe)) |-> !strobe.accept);

endmodule

// File: rtl/xfer_dpath.sv
module xfer_dpath
  import xfer_count_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  xfer_strobe_t      strobe,
  output logic [CNT_W-1:0]  countQ,
  output logic [ADDR_W-1:0] compAddrQ,
  output logic [ADDR_W-1:0] issueAddrQ,
  output logic              doneEv,
  output logic              wrapEv
);

  localparam int CNT_BYTES  = CNT_W / LANE_W;
  localparam int ADDR_BYTES = ADDR_W / LANE_W;

  logic [CNT_W-1:0]  countD;
  logic [ADDR_W-1:0] compD;
  logic [ADDR_W-1:0] issueD;

  always_comb begin
    countD = countQ;
    if (strobe.cntClr) begin
      countD = '0;
    end else if (|strobe.cntByteWe) begin
      for (int i = 0; i < CNT_BYTES; i++) begin
        if (strobe.cntByteWe[i]) countD[i*LANE_W +: LANE_W] = strobe.wdata;
      end
    end else if (strobe.accept) begin
      countD = countQ - CNT_W'(1);
    end
  end

  always_comb begin
    compD  = strobe.accept ? compAddrQ + ADDR_W'(1) : compAddrQ;
    issueD = strobe.issue ? issueAddrQ + ADDR_W'(1) : issueAddrQ;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (strobe.addrByteWe[i]) begin
        compD[i*LANE_W +: LANE_W]  = strobe.wdata;
        issueD[i*LANE_W +: LANE_W] = strobe.wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ     <= '0;
      compAddrQ  <= '0;
      issueAddrQ <= '0;
    end else begin
      countQ     <= countD;
      compAddrQ  <= compD;
      issueAddrQ <= issueD;
    end
  end

  assign doneEv = strobe.accept && (countQ == CNT_W'(1));
  assign wrapEv = strobe.accept && (countQ == '0);

  // R3: an accepted completion lowers the count by exactly one
  p_dec_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accept |=> countQ == $past(countQ) - CNT_W'(1));

  // R3: an accepted completion advances the completion address when not reloaded
  p_caddr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accept && !(|strobe.addrByteWe)) |=> compAddrQ == $past(compAddrQ) + ADDR_W'(1));

  // R4: issue activity alone never moves the count
  p_issue_only_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.accept && !strobe.cntClr && !(|strobe.cntByteWe)) |=> $stable(countQ));

  // R6: a wrap leaves the count at all ones
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrapEv |=> countQ == '1);

  // R9: the clear wins over everything else
  p_clr_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClr |=> countQ == '0);

  // R10: with no accepted completion and no reload, the completion address holds
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.accept && !(|strobe.addrByteWe)) |=> $stable(compAddrQ));

endmodule

// File: rtl/xfer_count_track.sv
module xfer_count_track
  import xfer_count_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [3:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic       xferIssue,
  input  logic       xferDone,
  output logic       irq
);

  localparam int CNT_BYTES  = CNT_W / LANE_W;
  localparam int ADDR_BYTES = ADDR_W / LANE_W;

  xfer_strobe_t      strobe;
  logic [CNT_W-1:0]  countQ;
  logic [ADDR_W-1:0] compAddrQ;
  logic [ADDR_W-1:0] issueAddrQ;
  logic              doneEv;
  logic              wrapEv;
  logic [STAT_W-1:0] statusQ;
  logic [STAT_W-1:0] enableQ;
  logic [31:0]       cntPad;
  logic [31:0]       compPad;
  logic [31:0]       issuePad;

  xfer_ctrl #(.CNT_BYTES(CNT_BYTES), .ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .xferDone(xferDone), .xferIssue(xferIssue), .doneEv(doneEv), .wrapEv(wrapEv),
    .strobe(strobe), .statusQ(statusQ), .enableQ(enableQ), .irq(irq)
  );

  xfer_dpath #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .countQ(countQ),
    .compAddrQ(compAddrQ), .issueAddrQ(issueAddrQ), .doneEv(doneEv), .wrapEv(wrapEv)
  );

  assign cntPad   = 32'(countQ);
  assign compPad  = 32'(compAddrQ);
  assign issuePad = 32'(issueAddrQ);

  always_comb begin
    regRdata = '0;
    if (regAddr < 4'(CNT_BYTES)) begin
      regRdata = cntPad[regAddr[1:0]*LANE_W +: LANE_W];
    end else if (regAddr == OFF_STAT) begin
      regRdata = 8'(statusQ);
    end else if (regAddr == OFF_EN) begin
      regRdata = 8'(enableQ);
    end else if (regAddr[3:2] == OFF_CADDR[3:2]) begin
      regRdata = compPad[regAddr[1:0]*LANE_W +: LANE_W];
    end else if (regAddr[3:2] == OFF_IADDR[3:2]) begin
      regRdata = issuePad[regAddr[1:0]*LANE_W +: LANE_W];
    end
  end

endmodule

// File: tb/tb_xfer_count_track.sv
`timescale 1ns/1ps
module tb_xfer_count_track;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       xferIssue = 1'b0;
  logic       xferDone = 1'b0;
  logic       irq;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  xfer_count_track dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .xferIssue(xferIssue), .xferDone(xferDone), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic rdCount(output logic [31:0] v);
    logic [7:0] b0, b1, b2;
    rd(4'd0, b0); rd(4'd1, b1); rd(4'd2, b2);
    v = {8'h00, b2, b1, b0};
  endtask

  task automatic rdWord(input logic [3:0] base, output logic [31:0] v);
    logic [7:0] b0, b1, b2, b3;
    rd(base, b0); rd(base + 4'd1, b1); rd(base + 4'd2, b2); rd(base + 4'd3, b3);
    v = {b3, b2, b1, b0};
  endtask

  task automatic rdStat(output logic [31:0] v);
    logic [7:0] b;
    rd(4'd4, b);
    v = 32'(b);
  endtask

  task automatic setCount(input logic [23:0] c);
    wr(4'd0, c[7:0]); wr(4'd1, c[15:8]); wr(4'd2, c[23:16]);
  endtask

  task automatic pulseDone(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); xferDone = 1'b1;
      @(negedge clk); xferDone = 1'b0;
    end
  endtask

  task automatic pulseIssue(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); xferIssue = 1'b1;
      @(negedge clk); xferIssue = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rdCount(v);         check("R1 count", v, 0);
    rdWord(4'd8, v);    check("R1 completion address", v, 0);
    rdWord(4'd12, v);   check("R1 issue address", v, 0);
    rdStat(v);          check("R1 status", v, 0);
    rd(4'd5, v[7:0]);   check("R1 enable", 32'(v[7:0]), 0);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_count_rw;
    logic [31:0] v;
    setCount(24'h123456);
    rdCount(v); check("R2 count lanes", v, 32'h0012_3456);
  endtask

  task automatic t_addr_load;
    logic [31:0] v;
    wr(4'd12, 8'hFE); wr(4'd13, 8'h00); wr(4'd14, 8'h00); wr(4'd15, 8'h10);
    rdWord(4'd12, v); check("R5 issue address load", v, 32'h1000_00FE);
    rdWord(4'd8, v);  check("R5 completion address load", v, 32'h1000_00FE);
    wr(4'd8, 8'hAA);
    rdWord(4'd8, v);  check("R11 completion address read-only", v, 32'h1000_00FE);
  endtask

  task automatic t_issue;
    logic [31:0] v;
    pulseIssue(3);
    rdWord(4'd12, v); check("R4 issue address advances", v, 32'h1000_0101);
    rdWord(4'd8, v);  check("R4 completion address unmoved", v, 32'h1000_00FE);
    rdCount(v);       check("R4 count unmoved", v, 32'h0012_3456);
  endtask

  task automatic t_complete;
    logic [31:0] v;
    pulseDone(2);
    rdCount(v);      check("R3 count decrements", v, 32'h0012_3454);
    rdWord(4'd8, v); check("R3 completion address carry", v, 32'h1000_0100);
    rdStat(v);       check("R3 no status mid-transfer", v, 0);
  endtask

  task automatic t_done_irq;
    logic [31:0] v;
    setCount(24'h000001);
    wr(4'd5, 8'h01);
    pulseDone(1);
    rdCount(v);      check("R6 count reaches zero", v, 0);
    rdStat(v);       check("R6 done flag", v, 32'h1);
    check("R8 irq on enabled done", 32'(irq), 1);
    rdWord(4'd8, v); check("R3 completion address", v, 32'h1000_0101);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr(4'd4, 8'h02);
    rdStat(v); check("R7 zero bit leaves done", v, 32'h1);
    wr(4'd4, 8'h01);
    rdStat(v); check("R7 one bit clears done", v, 0);
    check("R8 irq drops", 32'(irq), 0);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    pulseDone(1);
    rdCount(v); check("R6 wrap to all ones", v, 32'h00FF_FFFF);
    rdStat(v);  check("R6 wrap flag", v, 32'h2);
    check("R8 wrap masked", 32'(irq), 0);
    wr(4'd5, 8'h02);
    check("R8 wrap enabled", 32'(irq), 1);
    wr(4'd4, 8'h02);
    rdStat(v);  check("R7 clear wrap", v, 0);
    check("R8 irq low after clear", 32'(irq), 0);
  endtask

  task automatic t_clear_prio;
    logic [31:0] v;
    @(negedge clk);
    regWe = 1'b1; regAddr = 4'd3; regWdata = 8'h01; xferDone = 1'b1;
    @(negedge clk);
    regWe = 1'b0; xferDone = 1'b0;
    rdCount(v);      check("R9 clear wins", v, 0);
    rdWord(4'd8, v); check("R9 completion dropped", v, 32'h1000_0102);
    rdStat(v);       check("R9 no flag", v, 0);
    rd(4'd3, v[7:0]); check("R9 control reads zero", 32'(v[7:0]), 0);
  endtask

  task automatic t_write_prio;
    logic [31:0] v;
    setCount(24'h000005);
    @(negedge clk);
    regWe = 1'b1; regAddr = 4'd0; regWdata = 8'h20; xferDone = 1'b1;
    @(negedge clk);
    regWe = 1'b0; xferDone = 1'b0;
    rdCount(v);      check("R10 written value kept", v, 32'h20);
    rdWord(4'd8, v); check("R10 completion dropped", v, 32'h1000_0102);
    rdStat(v);       check("R10 no flag", v, 0);
  endtask

  task automatic t_set_wins;
    logic [31:0] v;
    wr(4'd0, 8'h01);
    @(negedge clk);
    regWe = 1'b1; regAddr = 4'd4; regWdata = 8'h01; xferDone = 1'b1;
    @(negedge clk);
    regWe = 1'b0; xferDone = 1'b0;
    rdStat(v);       check("R7 set wins over clear", v, 32'h1);
    rdCount(v);      check("R6 count zero", v, 0);
    rdWord(4'd8, v); check("R3 completion address", v, 32'h1000_0103);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_count_rw();
    t_addr_load();
    t_issue();
    t_complete();
    t_done_irq();
    t_w1c();
    t_wrap();
    t_clear_prio();
    t_write_prio();
    t_set_wins();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule